// File: doc/BRIEF.md
# Merging Write Buffer

This block sits between a write-through cache and the next memory level. Processor stores go into a small set of block-wide entries and are acknowledged at once. The entries are written to memory in the background whenever the memory port is free, so a store never waits on memory. Each entry holds one block-aligned address, one data slot per word and a per-word valid mask. A later store to a block that already has an entry is folded into that entry and does not use a new slot.

Stores whose address lies in the I/O region never fold and never receive folded data. Each one drains as its own write. Read misses from the cache share the memory port and are served before the background drain. The exception is a read whose block still has pending stores. The buffer then keeps draining in order until no entry for that block is left, and only then lets the read through. This way the read never returns stale data.

Top module: `merge_wbuf`

## Requirements
- R1: A store offered on `st_valid` is accepted in that same cycle (`st_ready` high) whenever fewer than 4 entries are occupied, whatever `mem_ack` does. The occupancy outputs reflect the store after the next rising edge.
- R2: A store below 0xF000_0000 folds into an entry when three conditions hold: its block (address bits 31:4) matches a pending non-I/O entry, that entry is not draining in this cycle, and the store is accepted. The word selected by address bits 3:2 is overwritten and its mask bit is set. `count` does not grow.
- R3: A store at address 0xF000_0000 or above always takes a fresh entry and is never folded into. Two such stores to one block produce two separate memory writes.
- R4: `st_ready` is low only when all 4 entries are occupied and the store cannot fold. A store that can fold is accepted while the buffer is full.
- R5: Entries drain oldest first. A drain drives `mem_wr`=1 and the block-aligned `mem_addr`. `mem_wmask` bit w is set exactly for the words that were stored, and word w travels in `mem_wdata` bits 32w+31:32w. Memory words whose mask bit is clear are left untouched.
- R6: A read miss (`rd_req`) whose block has no pending entry takes the memory port ahead of any drain (`mem_req`=1, `mem_wr`=0, `mem_addr` = block-aligned `rd_addr`). `rd_grant` rises in a cycle where `mem_ack` is high.
- R7: A read miss whose block matches a pending entry is held (`rd_grant` low) while entries drain in order. The read is granted only once no matching entry remains.
- R8: A store to the block of the entry that is draining in the same cycle allocates a new entry. The old entry leaves, the new one stays, and the two drain as separate writes.
- R9: `count` gives the number of occupied entries. `full` is high at 4 and `empty` is high at 0. After reset, `empty`=1, `full`=0, `count`=0 and `mem_req`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| st_valid | input | 1 | Processor store offered |
| st_addr | input | 32 | Store byte address (word aligned) |
| st_data | input | 32 | Store data word |
| st_ready | output | 1 | Store accepted this cycle |
| rd_req | input | 1 | Read miss wants the memory port |
| rd_addr | input | 32 | Read miss byte address |
| rd_grant | output | 1 | Read issued to memory this cycle |
| mem_req | output | 1 | Memory transfer request |
| mem_wr | output | 1 | 1 = masked block write, 0 = block read |
| mem_addr | output | 32 | Block-aligned memory address |
| mem_wdata | output | 128 | Write data, word w in bits 32w+31:32w |
| mem_wmask | output | 4 | Per-word write enable |
| mem_ack | input | 1 | Memory takes the transfer this cycle |
| full | output | 1 | All entries occupied |
| empty | output | 1 | No entry occupied |
| count | output | 3 | Occupied entry count |

## Verification
`st_ready`, `rd_grant` and the whole memory port are combinational from the registered entry state and the inputs of the same cycle, so they are valid in the cycle the stimulus is applied. `count`, `full` and `empty` change one rising edge after a store or a drain is taken. The bench drives inputs 2 ns after a rising edge and samples on the falling edge. Same-cycle results are read at the falling edge of the stimulus cycle, and occupancy is read at the falling edge one cycle later. A monitor applies each accepted memory write to a bench memory image under its mask. That image is compared word by word with a golden image built from the accepted stores in program order.

// File: rtl/mwb_pkg.sv
package mwb_pkg;

   // owner of the shared memory port in a given cycle
   typedef enum logic [1:0] {
      PORT_IDLE  = 2'd0,
      PORT_READ  = 2'd1,
      PORT_DRAIN = 2'd2
   } port_own_e;

   // true when v is a power of two
   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/mwb_slot.sv
module mwb_slot #(
   parameter int WORDS  = 4,
   parameter int DATA_W = 32,
   parameter int BLK_W  = 28,
   parameter int WIDX_W = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    i_alloc,
   input  logic                    i_merge,
   input  logic                    i_clear,
   input  logic [BLK_W-1:0]        i_blk,
   input  logic [WIDX_W-1:0]       i_word,
   input  logic [DATA_W-1:0]       i_data,
   input  logic                    i_io,
   output logic                    o_valid,
   output logic                    o_io,
   output logic [BLK_W-1:0]        o_blk,
   output logic [WORDS*DATA_W-1:0] o_data,
   output logic [WORDS-1:0]        o_mask
);

   logic [WORDS-1:0] word_sel;

   always_comb begin
      word_sel = '0;
      word_sel[i_word] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         o_valid <= 1'b0;
         o_io    <= 1'b0;
         o_blk   <= '0;
         o_mask  <= '0;
      end else if (i_alloc) begin
         o_valid <= 1'b1;
         o_io    <= i_io;
         o_blk   <= i_blk;
         o_mask  <= word_sel;
      end else if (i_merge) begin
         o_mask  <= o_mask | word_sel;
      end else if (i_clear) begin
         o_valid <= 1'b0;
         o_io    <= 1'b0;
         o_mask  <= '0;
      end
   end

   for (genvar w = 0; w < WORDS; w++) begin : g_word
      logic [DATA_W-1:0] word_q;
      always_ff @(posedge clk) begin
         if ((i_alloc || i_merge) && word_sel[w])
            word_q <= i_data;
      end
      assign o_data[w*DATA_W +: DATA_W] = word_q;
   end

   // R3: an I/O entry never receives folded data
   p_io_no_merge_r3: assert property (@(posedge clk) disable iff (!rst_n)
      i_merge |-> (o_valid && !o_io));

   // R2: folding only into a live entry that is not leaving
   p_merge_live_r2: assert property (@(posedge clk) disable iff (!rst_n)
      i_merge |-> (!i_clear && !i_alloc));

   // R5: a drained entry always carries at least one stored word
   p_clear_nonempty_r5: assert property (@(posedge clk) disable iff (!rst_n)
      i_clear |-> (o_valid && o_mask != '0));

endmodule

// File: rtl/mwb_order.sv
module mwb_order #(
   parameter int NUM_ENT = 4,
   parameter int PTR_W   = 2,
   parameter int CNT_W   = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic             pop,
   output logic [PTR_W-1:0] head,
   output logic [PTR_W-1:0] tail,
   output logic [CNT_W-1:0] count,
   output logic             full,
   output logic             empty
);

   localparam bit WRAP_FREE = mwb_pkg::is_pow2(NUM_ENT);

   logic [PTR_W-1:0] head_nx, tail_nx;

   if (WRAP_FREE) begin : g_wrap_pow2
      assign head_nx = head + PTR_W'(1);
      assign tail_nx = tail + PTR_W'(1);
   end else begin : g_wrap_cmp
      assign head_nx = (head == PTR_W'(NUM_ENT - 1)) ? '0 : head + PTR_W'(1);
      assign tail_nx = (tail == PTR_W'(NUM_ENT - 1)) ? '0 : tail + PTR_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head  <= '0;
         tail  <= '0;
         count <= '0;
      end else begin
         if (push) tail <= tail_nx;
         if (pop)  head <= head_nx;
         count <= count + CNT_W'(push) - CNT_W'(pop);
      end
   end

   assign full  = (count == CNT_W'(NUM_ENT));
   assign empty = (count == '0);

   // R9: occupancy never exceeds the number of slots
   p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(NUM_ENT));

   // R4: a new slot is only taken while one is free
   p_push_room_r4: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);

   // R5: the drain only removes an existing entry
   p_pop_live_r5: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);

endmodule

// File: rtl/mwb_arb.sv
module mwb_arb (
   input  logic                 rd_req,
   input  logic                 rd_hit,
   input  logic                 have_entry,
   input  logic                 mem_ack,
   output mwb_pkg::port_own_e   own,
   output logic                 mem_req,
   output logic                 rd_grant,
   output logic                 drain_fire
);

   import mwb_pkg::*;

   always_comb begin
      own = PORT_IDLE;
      if (rd_req && !rd_hit)
         own = PORT_READ;
      else if (have_entry)
         own = PORT_DRAIN;
   end

   assign mem_req    = (own != PORT_IDLE);
   assign rd_grant   = (own == PORT_READ) && mem_ack;
   assign drain_fire = (own == PORT_DRAIN) && mem_ack;

endmodule

// File: rtl/merge_wbuf.sv
module merge_wbuf #(
   parameter int                NUM_ENT = 4,
   parameter int                WORDS   = 4,
   parameter int                DATA_W  = 32,
   parameter int                ADDR_W  = 32,
   parameter logic [ADDR_W-1:0] IO_BASE = 'hF000_0000,
   localparam int               CNT_W   = $clog2(NUM_ENT + 1)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    st_valid,
   input  logic [ADDR_W-1:0]       st_addr,
   input  logic [DATA_W-1:0]       st_data,
   output logic                    st_ready,
   input  logic                    rd_req,
   input  logic [ADDR_W-1:0]       rd_addr,
   output logic                    rd_grant,
   output logic                    mem_req,
   output logic                    mem_wr,
   output logic [ADDR_W-1:0]       mem_addr,
   output logic [WORDS*DATA_W-1:0] mem_wdata,
   output logic [WORDS-1:0]        mem_wmask,
   input  logic                    mem_ack,
   output logic                    full,
   output logic                    empty,
   output logic [CNT_W-1:0]        count
);

   import mwb_pkg::*;

   localparam int BYTE_OFF = $clog2(DATA_W / 8);
   localparam int WIDX_W   = $clog2(WORDS);
   localparam int BLK_LSB  = BYTE_OFF + WIDX_W;
   localparam int BLK_W    = ADDR_W - BLK_LSB;
   localparam int PTR_W    = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1;

   // elaboration-time parameter checks
   if (!is_pow2(WORDS) || WORDS < 2) begin : g_bad_words
      $error("merge_wbuf: WORDS must be a power of two, at least 2");
   end
   if (!is_pow2(DATA_W) || DATA_W < 8) begin : g_bad_data
      $error("merge_wbuf: DATA_W must be a power of two, at least 8");
   end
   if (NUM_ENT < 2) begin : g_bad_depth
      $error("merge_wbuf: NUM_ENT must be at least 2");
   end
   if (IO_BASE[BLK_LSB-1:0] != '0) begin : g_bad_io
      $error("merge_wbuf: IO_BASE must be block aligned");
   end

   // address split
   logic [BLK_W-1:0]  st_blk, rd_blk;
   logic [WIDX_W-1:0] st_word;
   logic              st_io;
   logic              unused_low;

   assign st_blk     = st_addr[ADDR_W-1:BLK_LSB];
   assign st_word    = st_addr[BLK_LSB-1:BYTE_OFF];
   assign st_io      = (st_addr >= IO_BASE);
   assign rd_blk     = rd_addr[ADDR_W-1:BLK_LSB];
   assign unused_low = ^{st_addr[BYTE_OFF-1:0], rd_addr[BLK_LSB-1:0]};

   // slot array
   logic                    sl_valid [NUM_ENT];
   logic                    sl_io    [NUM_ENT];
   logic [BLK_W-1:0]        sl_blk   [NUM_ENT];
   logic [WORDS*DATA_W-1:0] sl_data  [NUM_ENT];
   logic [WORDS-1:0]        sl_mask  [NUM_ENT];
   logic [NUM_ENT-1:0]      fold_hit, rd_match, sl_alloc, sl_merge, sl_clear;

   logic [PTR_W-1:0] head, tail;
   logic             push, st_fire, can_fold, rd_hit, drain_fire;
   port_own_e        own;

   for (genvar i = 0; i < NUM_ENT; i++) begin : g_slot
      logic at_head, at_tail;
      assign at_head = (head == PTR_W'(i));
      assign at_tail = (tail == PTR_W'(i));

      assign fold_hit[i] = sl_valid[i] && !sl_io[i] && (sl_blk[i] == st_blk)
                           && !(drain_fire && at_head);
      assign rd_match[i] = sl_valid[i] && (sl_blk[i] == rd_blk);
      assign sl_alloc[i] = push && at_tail;
      assign sl_merge[i] = st_fire && can_fold && fold_hit[i];
      assign sl_clear[i] = drain_fire && at_head;

      mwb_slot #(
         .WORDS  (WORDS),
         .DATA_W (DATA_W),
         .BLK_W  (BLK_W),
         .WIDX_W (WIDX_W)
      ) i_slot (
         .clk     (clk),
         .rst_n   (rst_n),
         .i_alloc (sl_alloc[i]),
         .i_merge (sl_merge[i]),
         .i_clear (sl_clear[i]),
         .i_blk   (st_blk),
         .i_word  (st_word),
         .i_data  (st_data),
         .i_io    (st_io),
         .o_valid (sl_valid[i]),
         .o_io    (sl_io[i]),
         .o_blk   (sl_blk[i]),
         .o_data  (sl_data[i]),
         .o_mask  (sl_mask[i])
      );
   end

   // store acceptance
   assign can_fold = !st_io && (|fold_hit);
   assign st_ready = can_fold || !full;
   assign st_fire  = st_valid && st_ready;
   assign push     = st_fire && !can_fold;
   assign rd_hit   = |rd_match;

   mwb_order #(
      .NUM_ENT (NUM_ENT),
      .PTR_W   (PTR_W),
      .CNT_W   (CNT_W)
   ) i_order (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (push),
      .pop   (drain_fire),
      .head  (head),
      .tail  (tail),
      .count (count),
      .full  (full),
      .empty (empty)
   );

   mwb_arb i_arb (
      .rd_req     (rd_req),
      .rd_hit     (rd_hit),
      .have_entry (!empty),
      .mem_ack    (mem_ack),
      .own        (own),
      .mem_req    (mem_req),
      .rd_grant   (rd_grant),
      .drain_fire (drain_fire)
   );

   // memory port steering
   always_comb begin
      mem_wr    = (own == PORT_DRAIN);
      mem_addr  = '0;
      mem_wdata = '0;
      mem_wmask = '0;
      if (own == PORT_READ) begin
         mem_addr = {rd_blk, {BLK_LSB{1'b0}}};
      end else if (own == PORT_DRAIN) begin
         mem_addr  = {sl_blk[head], {BLK_LSB{1'b0}}};
         mem_wdata = sl_data[head];
         mem_wmask = sl_mask[head];
      end
   end

   // R4: a store stalls only against a full buffer
   p_stall_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (st_valid && !st_ready) |-> full);

   // R2: a fold that coincides with no drain leaves occupancy unchanged
   p_fold_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (st_fire && can_fold && !drain_fire) |=> (count == $past(count)));

   // R6: a clean read miss keeps writes off the port
   p_read_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !rd_hit) |-> (mem_req && !mem_wr));

   // R7: a read with pending data for its block waits behind drains
   p_hit_drains_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && rd_hit) |-> (mem_req && mem_wr && !rd_grant));

   // R8: a store to the block leaving this cycle replaces it one for one
   p_fresh_on_drain_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (st_fire && !st_io && drain_fire && !sl_io[head] && sl_blk[head] == st_blk)
      |=> (count == $past(count)));

   // R5: every drain write carries at least one word
   p_drain_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_wr) |-> (mem_wmask != '0));

endmodule

// File: tb/test_merge_wbuf.sv
`timescale 1ns/1ps
module test_merge_wbuf;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         st_valid = 1'b0;
   logic [31:0]  st_addr = '0;
   logic [31:0]  st_data = '0;
   logic         st_ready;
   logic         rd_req = 1'b0;
   logic [31:0]  rd_addr = '0;
   logic         rd_grant;
   logic         mem_req, mem_wr;
   logic [31:0]  mem_addr;
   logic [127:0] mem_wdata;
   logic [3:0]   mem_wmask;
   logic         mem_ack = 1'b0;
   logic         full, empty;
   logic [2:0]   count;

   int n_chk = 0;
   int n_bad = 0;
   int cyc   = 0;
   bit done  = 1'b0;

   // bench memory image and golden image, 64 words
   logic [31:0]  mem_img [64];
   logic [31:0]  gold    [64];
   // transfer log
   logic         lg_wr   [64];
   logic [31:0]  lg_addr [64];
   logic [3:0]   lg_mask [64];
   logic [127:0] lg_data [64];
   int           lg_n = 0;

   always #4 clk = ~clk;   // 125 MHz

   merge_wbuf i_merge_wbuf (
      .clk       (clk),
      .rst_n     (rst_n),
      .st_valid  (st_valid),
      .st_addr   (st_addr),
      .st_data   (st_data),
      .st_ready  (st_ready),
      .rd_req    (rd_req),
      .rd_addr   (rd_addr),
      .rd_grant  (rd_grant),
      .mem_req   (mem_req),
      .mem_wr    (mem_wr),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_wmask (mem_wmask),
      .mem_ack   (mem_ack),
      .full      (full),
      .empty     (empty),
      .count     (count)
   );

   function automatic int widx(input logic [31:0] a);
      return int'({(a >= 32'hF000_0000), a[6:4], a[3:2]});
   endfunction

   task automatic chk(input bit ok, input string req,
                      input logic [127:0] got, input logic [127:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h", req, got, exp);
      end
   endtask

   task automatic report();
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   endtask

   // memory model: log and apply every transfer taken on the port
   always @(negedge clk) begin
      if (rst_n && mem_req && mem_ack) begin
         if (lg_n < 64) begin
            lg_wr[lg_n]   = mem_wr;
            lg_addr[lg_n] = mem_addr;
            lg_mask[lg_n] = mem_wmask;
            lg_data[lg_n] = mem_wdata;
         end
         lg_n++;
         if (mem_wr) begin
            for (int w = 0; w < 4; w++)
               if (mem_wmask[w]) mem_img[widx(mem_addr + 32'(w * 4))] = mem_wdata[w*32 +: 32];
         end
      end
   end

   // watchdog
   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000 && !done) begin
         chk(1'b0, "R1 watchdog", 128'(cyc), 128'(150000));
         report();
      end
   end

   task automatic next_cycle();
      @(posedge clk);
      #2;
   endtask

   // offer a store until taken; after some refusals memory is released
   task automatic put_store(input logic [31:0] a, input logic [31:0] d, output bit acc);
      acc = 1'b0;
      st_valid = 1'b1;
      st_addr  = a;
      st_data  = d;
      for (int t = 0; t < 40; t++) begin
         @(negedge clk);
         acc = st_ready;
         next_cycle();
         if (acc) begin
            gold[widx(a)] = d;
            break;
         end
         if (t >= 6) mem_ack = 1'b1;
      end
      st_valid = 1'b0;
   endtask

   task automatic wait_empty();
      for (int t = 0; t < 2000; t++) begin
         @(negedge clk);
         if (empty) break;
      end
      next_cycle();
   endtask

   initial begin
      bit acc;
      int base;
      for (int k = 0; k < 64; k++) begin
         mem_img[k] = '0;
         gold[k]    = '0;
      end

      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;

      // reset state (R9, R1)
      @(negedge clk);
      chk(empty === 1'b1 && full === 1'b0, "R9 reset flags", {full, empty}, 2'b01);
      chk(count === 3'd0, "R9 reset count", count, 0);
      chk(mem_req === 1'b0, "R9 reset port idle", mem_req, 0);
      chk(st_ready === 1'b1, "R1 ready after reset", st_ready, 1);
      next_cycle();

      // fill with memory stalled
      put_store(32'h0000_0100, 32'hA000_0000, acc);
      chk(acc, "R1 store taken without memory", acc, 1);
      @(negedge clk);
      chk(count === 3'd1, "R1 count after first store", count, 1);
      next_cycle();
      put_store(32'h0000_0108, 32'hA000_0002, acc);
      @(negedge clk);
      chk(count === 3'd1, "R2 fold keeps count", count, 1);
      next_cycle();
      put_store(32'h0000_0114, 32'hB000_0001, acc);
      put_store(32'hF000_0000, 32'hC000_0000, acc);
      put_store(32'hF000_0004, 32'hC000_0001, acc);
      @(negedge clk);
      chk(count === 3'd4, "R3 io stores take own entries", count, 4);
      chk(full === 1'b1 && empty === 1'b0, "R9 full flags", {full, empty}, 2'b10);
      next_cycle();
      put_store(32'h0000_010C, 32'hA000_0003, acc);
      chk(acc, "R4 fold accepted while full", acc, 1);
      @(negedge clk);
      chk(count === 3'd4, "R4 count after full fold", count, 4);
      next_cycle();
      st_valid = 1'b1;
      st_addr  = 32'h0000_0120;
      st_data  = 32'hDEAD_0000;
      @(negedge clk);
      chk(st_ready === 1'b0, "R4 stall when full and no fold", st_ready, 0);
      next_cycle();
      st_valid = 1'b0;
      @(negedge clk);
      chk(count === 3'd4, "R4 stalled store not taken", count, 4);
      chk(mem_req && mem_wr && mem_addr === 32'h0000_0100, "R5 oldest entry on port",
          mem_addr, 32'h100);
      chk(mem_wmask === 4'b1101, "R5 mask of folded entry", mem_wmask, 4'b1101);
      chk(mem_wdata[31:0] === 32'hA000_0000 && mem_wdata[95:64] === 32'hA000_0002
          && mem_wdata[127:96] === 32'hA000_0003, "R2 folded words in place",
          mem_wdata, 128'hA0000003_A0000002_00000000_A0000000);
      next_cycle();

      // read miss to a clean block beats the drain
      rd_req  = 1'b1;
      rd_addr = 32'h0000_0134;
      @(negedge clk);
      chk(mem_req && !mem_wr && mem_addr === 32'h0000_0130, "R6 read takes port",
          {mem_wr, mem_addr}, 33'h0_0000_0130);
      next_cycle();
      // read miss to a pending block must wait
      rd_addr = 32'h0000_0118;
      @(negedge clk);
      chk(mem_wr === 1'b1 && mem_addr === 32'h0000_0100 && rd_grant === 1'b0,
          "R7 pending block drains first", {rd_grant, mem_addr}, 33'h0_0000_0100);
      next_cycle();
      mem_ack = 1'b1;
      for (int t = 0; t < 20; t++) begin
         @(negedge clk);
         if (rd_grant) break;
      end
      next_cycle();
      rd_req = 1'b0;
      wait_empty();
      chk(lg_n == 5, "R5 transfer count", 128'(lg_n), 5);
      chk(lg_wr[0] && lg_addr[0] === 32'h100 && lg_mask[0] === 4'b1101,
          "R5 first drain", {lg_addr[0], lg_mask[0]}, {32'h100, 4'b1101});
      chk(lg_wr[1] && lg_addr[1] === 32'h110 && lg_mask[1] === 4'b0010,
          "R7 second drain before read", {lg_addr[1], lg_mask[1]}, {32'h110, 4'b0010});
      chk(!lg_wr[2] && lg_addr[2] === 32'h110, "R7 read after its block drained",
          {lg_wr[2], lg_addr[2]}, {1'b0, 32'h110});
      chk(lg_wr[3] && lg_addr[3] === 32'hF000_0000 && lg_mask[3] === 4'b0001,
          "R3 first io write", {lg_addr[3], lg_mask[3]}, {32'hF000_0000, 4'b0001});
      chk(lg_wr[4] && lg_addr[4] === 32'hF000_0000 && lg_mask[4] === 4'b0010,
          "R3 second io write", {lg_addr[4], lg_mask[4]}, {32'hF000_0000, 4'b0010});
      chk(mem_img[widx(32'h104)] === 32'h0, "R5 unmasked word untouched",
          mem_img[widx(32'h104)], 0);

      // store to the block draining this very cycle
      mem_ack = 1'b0;
      put_store(32'h0000_0140, 32'hE000_0000, acc);
      base = lg_n;
      mem_ack = 1'b1;
      put_store(32'h0000_0144, 32'hE000_0001, acc);
      @(negedge clk);
      chk(acc && count === 3'd0 + 3'd1 - 3'd0 - 3'd0, "R8 fresh entry during drain", count, 1);
      wait_empty();
      chk(lg_n == base + 2, "R8 two separate writes", 128'(lg_n - base), 2);
      chk(lg_mask[base] === 4'b0001 && lg_mask[base+1] === 4'b0010
          && lg_addr[base+1] === 32'h140, "R8 masks of split writes",
          {lg_mask[base], lg_mask[base+1]}, 8'h12);

      // sweep: mixed blocks, words, io and memory stalls
      for (int i = 0; i < 96; i++) begin
         logic [31:0] a;
         a = ((i % 6) == 5) ? 32'hF000_0000 : 32'h0000_0100;
         a = a + 32'(((i * 3 + i / 5) % 4) * 16) + 32'(((i * 7) % 4) * 4);
         mem_ack = ((i % 5) >= 2);
         put_store(a, 32'h5A00_0000 + 32'(i * 257), acc);
         if (!acc) chk(1'b0, "R4 sweep store never taken", 0, 1);
      end
      mem_ack = 1'b1;
      wait_empty();
      for (int k = 0; k < 64; k++)
         chk(mem_img[k] === gold[k], "R5 golden image word", mem_img[k], gold[k]);
      @(negedge clk);
      chk(empty === 1'b1 && full === 1'b0 && count === 3'd0, "R9 drained to empty",
          {full, empty, count}, 5'b01000);

      done = 1'b1;
      report();
   end

endmodule